// File: doc/BRIEF.md
# Port Clock-Tree Configuration Sequencer

This block programs the clock-generation unit for one switch port without software stepping through it. When `start_i` is pulsed, it latches the port's interface mode, MAC/PHY role, link speed and port index. It then works through an ordered list of 32-bit register writes on a valid/ready write port. Each write is an address and a data word. The mode, role and speed decide which clock sinks are reprogrammed, the order of the writes, and the source each sink takes.

A flat address table supplies the address of every sink for the selected port. A table entry equal to the reserved marker means that sink does not exist, and its write is skipped without complaint. When the sequence is over, `done_o` pulses for one cycle. If the mode or port is invalid, or the bus returns an error, the sequence stops early and `err_o` is raised together with that pulse.

FSM states:
- `CS_IDLE`: waits for a start pulse.
- `CS_PLAN`: looks up the current step. It either skips an absent sink and stays in `CS_PLAN`, loads a write and moves to `CS_ISSUE`, moves to `CS_FINISH` at the end of the list, or moves to `CS_ABORT` on an invalid configuration.
- `CS_ISSUE`: holds the write until it is accepted. It then goes back to `CS_PLAN`, or to `CS_ABORT` if the bus reported an error.
- `CS_FINISH` and `CS_ABORT`: each signals done for one cycle and returns to `CS_IDLE`.

Top module: `clk_tree_cfg_seq`

## Requirements
- R1: Each clock-mux word carries its 5-bit source in bits 28:24, a 1 in bit 11 (auto-block) and a 0 in bit 0 (enabled). The source codes are:
  - port n transmit input = 2n, port n receive input = 2n+1;
  - PLL0 = 0x0B, PLL1 = 0x0E;
  - divider n = 0x11+n.
- R2: The divider word is built as follows, so that enabled/1 = 0x0A000800, enabled/10 = 0x0A000824 and off = 0x0A000801:
  - source 0x0A in bits 28:24 and a 1 in bit 11;
  - (factor−1) in bits 5:2;
  - bit 0 set when the divider is off.
- R3: MII (`mode_i`=0) writes the sinks in this order:
  - divider: off for MAC (`role_i`=0), factor 1 for PHY (`role_i`=1);
  - MII transmit clock: the port's transmit input for MAC, divider n for PHY;
  - MII receive clock: the port's receive input;
  - PHY role only: the external transmit clock and then the external receive clock, both from divider n.
- R4: RGMII (`mode_i`=2) sets the divider from the speed, then writes the RGMII transmit clock:
  - speed 2 (1000): divider off, transmit clock from PLL0;
  - speed 1 (100): divider factor 1, transmit clock from divider n;
  - speed 0 (10): divider factor 10, transmit clock from divider n;
  - speed 3 (unknown): both clock writes are skipped, with no error.
- R5: RMII (`mode_i`=1) writes the sinks in this order:
  - MAC role only: PLL1 as 0x0A010941, then PLL1 as 0x0A010940;
  - divider off;
  - reference clock from the port's transmit input;
  - MAC role only: the external transmit clock from PLL1.
- R6: SGMII (`mode_i`=3) issues only the pad write. A mode of 4..7, or a port index of NUM_PORTS or more, issues no write and ends with an error.
- R7: A sink whose table address equals the reserved marker is skipped. The writes after it still happen in order.
- R8: Every sequence that succeeds ends with the receive pad word 0x02020312 (bits 9:8 = 3, which pulls the receive control inputs down).
- R9: While `wr_valid_o` is high and `wr_ready_i` is low, `wr_valid_o`, `wr_addr_o` and `wr_data_o` do not change.
- R10: If `wr_err_i` is high when a write is accepted, no further write is issued, `done_o` pulses and `err_o` rises.
- R11: A start pulse that arrives while `busy_o` is high is ignored, together with any change to the configuration inputs.
- R12: `done_o` is high for exactly one cycle per sequence. `err_o` stays as it is until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only in idle |
| mode_i | input | 3 | Interface mode: 0 MII, 1 RMII, 2 RGMII, 3 SGMII |
| role_i | input | 1 | 0 MAC, 1 PHY |
| speed_i | input | 2 | 0 = 10, 1 = 100, 2 = 1000, 3 = unknown |
| port_i | input | PW | Port index |
| addr_tbl_i | input | 10*AW | Sink addresses, sink k in bits k*AW +: AW. Sink order: divider, MII transmit, MII receive, MII external transmit, MII external receive, RGMII transmit, RMII reference, RMII external transmit, PLL1, receive pad |
| wr_valid_o | output | 1 | Write request |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | 32 | Write data |
| wr_ready_i | input | 1 | Write accepted |
| wr_err_i | input | 1 | Error response, sampled when the write is accepted |
| busy_o | output | 1 | Sequencer not idle |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 1 | Last sequence aborted |

## Verification
The embedded assertions check five properties on every cycle:
- the auto-block bit in every mux word;
- that no write ever targets the reserved address;
- that the stalled write is held steady;
- that the PLL release write only follows its setup write;
- the single-cycle shape of done and its coincidence with a rising error.

Only the bench's scenarios can show the full content of each sequence: which sinks are written, in what order, with which words, per mode, role, speed and port. The same holds for skipping a missing sink, for where an abort cuts the sequence off, and for a stray start being ignored.

// File: rtl/clk_cfg_pkg.sv
package clk_cfg_pkg;

    localparam int DW        = 32;
    localparam int NUM_SINKS = 10;
    localparam int MAX_STEPS = 8;
    localparam int IW        = $clog2(MAX_STEPS);

    typedef enum logic [1:0] {
        SPD_10   = 2'd0,
        SPD_100  = 2'd1,
        SPD_1000 = 2'd2,
        SPD_NONE = 2'd3
    } speed_e;

    typedef enum logic [3:0] {
        SNK_DIV     = 4'd0,
        SNK_MII_TX  = 4'd1,
        SNK_MII_RX  = 4'd2,
        SNK_MII_XTX = 4'd3,
        SNK_MII_XRX = 4'd4,
        SNK_RG_TX   = 4'd5,
        SNK_RM_REF  = 4'd6,
        SNK_RM_XTX  = 4'd7,
        SNK_PLL1    = 4'd8,
        SNK_PAD_RX  = 4'd9
    } sink_e;

    typedef enum logic [1:0] {
        ACT_WRITE = 2'd0,
        ACT_END   = 2'd1,
        ACT_FAIL  = 2'd2
    } act_e;

    typedef struct packed {
        act_e          act;
        sink_e         sink;
        logic [DW-1:0] data;
    } step_t;

    localparam logic [4:0] SRC_REF25    = 5'h0A;
    localparam logic [4:0] SRC_PLL0     = 5'h0B;
    localparam logic [4:0] SRC_PLL1     = 5'h0E;
    localparam logic [4:0] SRC_DIV_BASE = 5'h11;

    // clock-mux control word: source, auto-block set, enabled
    function automatic logic [DW-1:0] mux_word(input logic [4:0] src);
        logic [DW-1:0] w;
        w        = '0;
        w[28:24] = src;
        w[11]    = 1'b1;
        w[0]     = 1'b0;
        return w;
    endfunction

    // integer divider word fed from the 25 MHz reference
    function automatic logic [DW-1:0] div_word(input logic enable, input logic [3:0] fm1);
        logic [DW-1:0] w;
        w        = '0;
        w[28:24] = SRC_REF25;
        w[11]    = 1'b1;
        w[5:2]   = fm1;
        w[0]     = ~enable;
        return w;
    endfunction

    // PLL1 control word for a 50 MHz output
    function automatic logic [DW-1:0] pll1_word(input logic pd);
        logic [DW-1:0] w;
        w        = '0;
        w[28:24] = SRC_REF25;  // input clock select
        w[23:16] = 8'h01;      // feedback multiplier
        w[11]    = 1'b1;       // auto-block
        w[9:8]   = 2'd1;       // post divider
        w[7]     = 1'b0;       // direct output off
        w[6]     = 1'b1;       // feedback select
        w[1]     = 1'b0;       // no bypass
        w[0]     = pd;
        return w;
    endfunction

    // receive pad word: plain inputs, control lines pulled down
    function automatic logic [DW-1:0] pad_rx_word();
        logic [DW-1:0] w;
        w        = '0;
        w[25:24] = 2'd2;
        w[17:16] = 2'd2;
        w[9:8]   = 2'd3;
        w[4:3]   = 2'd2;
        w[1:0]   = 2'd2;
        return w;
    endfunction

    function automatic step_t mk_step(input sink_e s, input logic [DW-1:0] d);
        step_t t;
        t.act  = ACT_WRITE;
        t.sink = s;
        t.data = d;
        return t;
    endfunction

endpackage

// File: rtl/clk_cfg_plan.sv
module clk_cfg_plan
    import clk_cfg_pkg::*;
#(
    parameter int PW        = 3,
    parameter int NUM_PORTS = 5
) (
    input  logic [2:0]    mode_i,
    input  logic          role_i,
    input  logic [1:0]    speed_i,
    input  logic [PW-1:0] port_i,
    input  logic [IW-1:0] idx_i,
    output step_t         step_o
);

    step_t         lst [MAX_STEPS];
    logic [IW-1:0] n;
    logic [4:0]    pn;
    logic [4:0]    tx_src;
    logic [4:0]    rx_src;
    logic [4:0]    dv_src;
    logic          cfg_bad;

    always_comb begin
        pn      = 5'(port_i);
        tx_src  = pn << 1;
        rx_src  = (pn << 1) | 5'd1;
        dv_src  = SRC_DIV_BASE + pn;
        cfg_bad = (mode_i > 3'd3) || (int'(port_i) >= NUM_PORTS);
        for (int i = 0; i < MAX_STEPS; i++) begin
            lst[i] = '{act: ACT_END, sink: SNK_DIV, data: '0};
        end
        n = '0;
        if (cfg_bad) begin
            lst[0].act = ACT_FAIL;
        end else begin
            unique case (mode_i[1:0])
                2'd0: begin // MII
                    lst[n] = mk_step(SNK_DIV, div_word(role_i, 4'd0));
                    n = n + 1'b1;
                    lst[n] = mk_step(SNK_MII_TX, mux_word(role_i ? dv_src : tx_src));
                    n = n + 1'b1;
                    lst[n] = mk_step(SNK_MII_RX, mux_word(rx_src));
                    n = n + 1'b1;
                    if (role_i) begin
                        lst[n] = mk_step(SNK_MII_XTX, mux_word(dv_src));
                        n = n + 1'b1;
                        lst[n] = mk_step(SNK_MII_XRX, mux_word(dv_src));
                        n = n + 1'b1;
                    end
                end
                2'd1: begin // RMII
                    if (!role_i) begin
                        lst[n] = mk_step(SNK_PLL1, pll1_word(1'b1));
                        n = n + 1'b1;
                        lst[n] = mk_step(SNK_PLL1, pll1_word(1'b0));
                        n = n + 1'b1;
                    end
                    lst[n] = mk_step(SNK_DIV, div_word(1'b0, 4'd0));
                    n = n + 1'b1;
                    lst[n] = mk_step(SNK_RM_REF, mux_word(tx_src));
                    n = n + 1'b1;
                    if (!role_i) begin
                        lst[n] = mk_step(SNK_RM_XTX, mux_word(SRC_PLL1));
                        n = n + 1'b1;
                    end
                end
                2'd2: begin // RGMII
                    unique case (speed_e'(speed_i))
                        SPD_1000: begin
                            lst[n] = mk_step(SNK_DIV, div_word(1'b0, 4'd0));
                            n = n + 1'b1;
                            lst[n] = mk_step(SNK_RG_TX, mux_word(SRC_PLL0));
                            n = n + 1'b1;
                        end
                        SPD_100: begin
                            lst[n] = mk_step(SNK_DIV, div_word(1'b1, 4'd0));
                            n = n + 1'b1;
                            lst[n] = mk_step(SNK_RG_TX, mux_word(dv_src));
                            n = n + 1'b1;
                        end
                        SPD_10: begin
                            lst[n] = mk_step(SNK_DIV, div_word(1'b1, 4'd9));
                            n = n + 1'b1;
                            lst[n] = mk_step(SNK_RG_TX, mux_word(dv_src));
                            n = n + 1'b1;
                        end
                        default: begin
                        end
                    endcase
                end
                default: begin // SGMII: no clock writes
                end
            endcase
            lst[n] = mk_step(SNK_PAD_RX, pad_rx_word());
        end
        step_o = lst[idx_i];
    end

endmodule

// File: rtl/clk_cfg_addr_sel.sv
module clk_cfg_addr_sel
    import clk_cfg_pkg::*;
#(
    parameter int             AW       = 32,
    parameter logic [AW-1:0]  RSV_ADDR = '1
) (
    input  logic [NUM_SINKS*AW-1:0] tbl_i,
    input  sink_e                   sel_i,
    output logic [AW-1:0]           addr_o,
    output logic                    absent_o
);

    logic [AW-1:0] ent [NUM_SINKS];

    generate
        for (genvar g = 0; g < NUM_SINKS; g++) begin : g_split
            assign ent[g] = tbl_i[g*AW +: AW];
        end
    endgenerate

    always_comb begin
        addr_o = RSV_ADDR;
        if (int'(sel_i) < NUM_SINKS) begin
            addr_o = ent[sel_i];
        end
        absent_o = (addr_o == RSV_ADDR);
    end

endmodule

// File: rtl/clk_cfg_wport.sv
module clk_cfg_wport
    import clk_cfg_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic          ready_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] data_o,
    output logic          fire_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            addr_o  <= '0;
            data_o  <= '0;
        end else if (load_i) begin
            valid_o <= 1'b1;
            addr_o  <= addr_i;
            data_o  <= data_i;
        end else if (fire_o) begin
            valid_o <= 1'b0;
        end
    end

    assign fire_o = valid_o && ready_i;

    // R9: a stalled write keeps its request, address and data
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(data_o));

    // R9: a new write is never loaded over a pending one
    assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !valid_o);

endmodule

// File: rtl/clk_tree_cfg_seq.sv
module clk_tree_cfg_seq
    import clk_cfg_pkg::*;
#(
    parameter int            PW        = 3,
    parameter int            NUM_PORTS = 5,
    parameter int            AW        = 32,
    parameter logic [AW-1:0] RSV_ADDR  = '1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [2:0]              mode_i,
    input  logic                    role_i,
    input  logic [1:0]              speed_i,
    input  logic [PW-1:0]           port_i,
    input  logic [NUM_SINKS*AW-1:0] addr_tbl_i,
    output logic                    wr_valid_o,
    output logic [AW-1:0]           wr_addr_o,
    output logic [DW-1:0]           wr_data_o,
    input  logic                    wr_ready_i,
    input  logic                    wr_err_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    err_o
);

    typedef enum logic [2:0] {
        CS_IDLE   = 3'd0,
        CS_PLAN   = 3'd1,
        CS_ISSUE  = 3'd2,
        CS_FINISH = 3'd3,
        CS_ABORT  = 3'd4
    } state_e;

    state_e        st, nxt;
    logic [2:0]    mode_q;
    logic          role_q;
    logic [1:0]    speed_q;
    logic [PW-1:0] port_q;
    logic [IW-1:0] idx_q;
    logic          err_q;
    logic          pll_seen_q;

    step_t         step;
    logic [AW-1:0] sink_addr;
    logic          absent;
    logic          load;
    logic          adv;
    logic          fire;

    clk_cfg_plan #(.PW(PW), .NUM_PORTS(NUM_PORTS)) u_plan (
        .mode_i (mode_q),
        .role_i (role_q),
        .speed_i(speed_q),
        .port_i (port_q),
        .idx_i  (idx_q),
        .step_o (step)
    );

    clk_cfg_addr_sel #(.AW(AW), .RSV_ADDR(RSV_ADDR)) u_addr (
        .tbl_i   (addr_tbl_i),
        .sel_i   (step.sink),
        .addr_o  (sink_addr),
        .absent_o(absent)
    );

    clk_cfg_wport #(.AW(AW)) u_wport (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .addr_i (sink_addr),
        .data_i (step.data),
        .ready_i(wr_ready_i),
        .valid_o(wr_valid_o),
        .addr_o (wr_addr_o),
        .data_o (wr_data_o),
        .fire_o (fire)
    );

    // next-state decision
    always_comb begin
        nxt  = st;
        load = 1'b0;
        adv  = 1'b0;
        unique case (st)
            CS_IDLE: begin
                if (start_i) nxt = CS_PLAN;
            end
            CS_PLAN: begin
                unique case (step.act)
                    ACT_FAIL: nxt = CS_ABORT;
                    ACT_END:  nxt = CS_FINISH;
                    default: begin
                        if (absent) begin
                            adv = 1'b1;
                        end else begin
                            load = 1'b1;
                            nxt  = CS_ISSUE;
                        end
                    end
                endcase
            end
            CS_ISSUE: begin
                if (fire) begin
                    if (wr_err_i) begin
                        nxt = CS_ABORT;
                    end else begin
                        adv = 1'b1;
                        nxt = CS_PLAN;
                    end
                end
            end
            CS_FINISH, CS_ABORT: nxt = CS_IDLE;
            default: nxt = CS_IDLE;
        endcase
    end

    // state register and sequence context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= CS_IDLE;
            mode_q     <= '0;
            role_q     <= 1'b0;
            speed_q    <= '0;
            port_q     <= '0;
            idx_q      <= '0;
            err_q      <= 1'b0;
            pll_seen_q <= 1'b0;
        end else begin
            st <= nxt;
            if (st == CS_IDLE && start_i) begin
                mode_q     <= mode_i;
                role_q     <= role_i;
                speed_q    <= speed_i;
                port_q     <= port_i;
                idx_q      <= '0;
                err_q      <= 1'b0;
                pll_seen_q <= 1'b0;
            end else begin
                if (adv) idx_q <= idx_q + 1'b1;
                if (nxt == CS_ABORT && st != CS_ABORT) err_q <= 1'b1;
                if (fire && wr_data_o == pll1_word(1'b1)) pll_seen_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy_o = (st != CS_IDLE);
        done_o = (st == CS_FINISH) || (st == CS_ABORT);
        err_o  = err_q;
    end

    // R1: every mux/divider/PLL word carries auto-block; the pad word does not
    assert_autoblock_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && (wr_data_o != pad_rx_word()) |-> wr_data_o[11]);

    // R7: no request ever targets an absent sink
    assert_no_rsv_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (wr_addr_o != RSV_ADDR));

    // R5: PLL1 power-down is released only after its setup write was accepted
    assert_pll_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && (wr_data_o == pll1_word(1'b0)) |-> pll_seen_q);

    // R12: done lasts a single cycle
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: a rising error coincides with the done pulse
    assert_abort_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);

    // R11: the latched configuration cannot change while busy
    assert_ctx_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(mode_q) && $stable(role_q) && $stable(speed_q) && $stable(port_q));

endmodule

// File: tb/tb_clk_tree_cfg_seq.sv
module tb_clk_tree_cfg_seq;

    localparam int AW   = 32;
    localparam int NSK  = 10;
    localparam int NV   = 11;
    localparam logic [31:0] RSV  = 32'hFFFF_FFFF;
    localparam logic [31:0] BASE = 32'h0010_0000;
    localparam logic [31:0] PADW = 32'h0202_0312;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] mode = '0;
    logic role = 1'b0;
    logic [1:0] speed = '0;
    logic [2:0] port = '0;
    logic [NSK*AW-1:0] tbl;
    logic wr_valid, wr_ready, wr_err, busy, done, err;
    logic [31:0] wr_addr, wr_data;

    always #4 clk = ~clk;  // 125 MHz

    clk_tree_cfg_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .role_i(role),
        .speed_i(speed), .port_i(port), .addr_tbl_i(tbl),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .wr_ready_i(wr_ready), .wr_err_i(wr_err),
        .busy_o(busy), .done_o(done), .err_o(err)
    );

    // vectors: cfg = {mode, role, speed, port}
    localparam logic [8:0] V_CFG [NV] = '{
        {3'd0, 1'b0, 2'd0, 3'd0}, {3'd0, 1'b1, 2'd0, 3'd2}, {3'd1, 1'b0, 2'd0, 3'd1},
        {3'd1, 1'b1, 2'd0, 3'd4}, {3'd2, 1'b0, 2'd2, 3'd3}, {3'd2, 1'b1, 2'd1, 3'd0},
        {3'd2, 1'b0, 2'd0, 3'd4}, {3'd2, 1'b0, 2'd3, 3'd1}, {3'd3, 1'b0, 2'd0, 3'd2},
        {3'd5, 1'b0, 2'd0, 3'd0}, {3'd0, 1'b0, 2'd0, 3'd5}};
    localparam int V_N [NV] = '{4, 6, 6, 3, 3, 3, 3, 1, 1, 0, 0};
    localparam logic V_ERR [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1};
    localparam int V_SNK [NV][6] = '{
        '{0, 1, 2, 9, 0, 0}, '{0, 1, 2, 3, 4, 9}, '{8, 8, 0, 6, 7, 9},
        '{0, 6, 9, 0, 0, 0}, '{0, 5, 9, 0, 0, 0}, '{0, 5, 9, 0, 0, 0},
        '{0, 5, 9, 0, 0, 0}, '{9, 0, 0, 0, 0, 0}, '{9, 0, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0, 0}};
    localparam logic [31:0] V_DAT [NV][6] = '{
        '{32'h0A000801, 32'h00000800, 32'h01000800, PADW, 0, 0},
        '{32'h0A000800, 32'h13000800, 32'h05000800, 32'h13000800, 32'h13000800, PADW},
        '{32'h0A010941, 32'h0A010940, 32'h0A000801, 32'h02000800, 32'h0E000800, PADW},
        '{32'h0A000801, 32'h08000800, PADW, 0, 0, 0},
        '{32'h0A000801, 32'h0B000800, PADW, 0, 0, 0},
        '{32'h0A000800, 32'h11000800, PADW, 0, 0, 0},
        '{32'h0A000824, 32'h15000800, PADW, 0, 0, 0},
        '{PADW, 0, 0, 0, 0, 0}, '{PADW, 0, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0}, '{0, 0, 0, 0, 0, 0}};

    int checks = 0;
    int errors = 0;

    // write monitor
    logic [31:0] lg_a [16];
    logic [31:0] lg_d [16];
    int lg_n = 0;
    int done_n = 0;
    int stall_bad = 0;
    logic clr = 1'b0;
    logic prev_stall = 1'b0;
    logic [31:0] prev_a = '0, prev_d = '0;
    logic stall = 1'b0;
    logic err_arm = 1'b0;
    int err_at = 0;
    logic [1:0] rc = '0;

    assign wr_err = err_arm && (lg_n == err_at);

    always @(posedge clk) begin
        if (clr) begin
            lg_n   <= 0;
            done_n <= 0;
        end else begin
            if (wr_valid && wr_ready) begin
                if (lg_n < 16) begin
                    lg_a[lg_n] <= wr_addr;
                    lg_d[lg_n] <= wr_data;
                end
                lg_n <= lg_n + 1;
            end
            if (done) done_n <= done_n + 1;
        end
        if (prev_stall && (!wr_valid || wr_addr != prev_a || wr_data != prev_d))
            stall_bad <= stall_bad + 1;
        prev_stall <= wr_valid && !wr_ready;
        prev_a     <= wr_addr;
        prev_d     <= wr_data;
    end

    always @(negedge clk) begin
        rc       <= rc + 2'd1;
        wr_ready <= !stall || (rc == 2'd3);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [8:0] cfg);
        case (cfg[8:6])
            3'd0: return "R3";
            3'd1: return "R5";
            3'd2: return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic launch(input logic [8:0] cfg);
        @(negedge clk);
        clr = 1'b1;
        {mode, role, speed, port} = cfg;
        @(negedge clk);
        clr   = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    // compare log with vector v, leaving out entries of sink skip_snk
    task automatic cmp_vec(input int v, input int skip_snk, input string req);
        int k = 0;
        for (int i = 0; i < V_N[v]; i++) begin
            if (V_SNK[v][i] != skip_snk) begin
                chk(lg_a[k] == BASE + 32'(V_SNK[v][i] * 256), req, lg_a[k], BASE + 32'(V_SNK[v][i] * 256));
                // R1 / R2 / R8 word contents
                chk(lg_d[k] == V_DAT[v][i], req, lg_d[k], V_DAT[v][i]);
                k++;
            end
        end
        chk(lg_n == k, req, 32'(lg_n), 32'(k));
        chk(err == V_ERR[v], req, 32'(err), 32'(V_ERR[v]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < NSK; s++) tbl[s*AW +: AW] = BASE + 32'(s * 256);
        repeat (3) @(negedge clk);
        // reset state
        chk(!wr_valid && !busy && !done && !err, "R12 reset", {wr_valid, busy, done, err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk: R1..R6, R8
        for (int v = 0; v < NV; v++) begin
            launch(V_CFG[v]);
            wait_done();
            cmp_vec(v, -1, req_of(V_CFG[v]));
            chk(!done && done_n == 1, "R12 done pulse", 32'(done_n), 1);
        end

        // R7: absent MII receive sink is skipped, rest continues
        tbl[2*AW +: AW] = RSV;
        launch(V_CFG[1]);
        wait_done();
        cmp_vec(1, 2, "R7");
        tbl[2*AW +: AW] = BASE + 32'(2 * 256);

        // R9 + R11: stalled writes, stray start with other inputs mid-run
        stall = 1'b1;
        launch(V_CFG[1]);
        repeat (4) @(negedge clk);
        chk(busy, "R11 busy", 32'(busy), 1);
        {mode, role, speed, port} = {3'd3, 1'b0, 2'd0, 3'd0};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        cmp_vec(1, -1, "R11");
        chk(done_n == 1, "R11 single done", 32'(done_n), 1);
        chk(stall_bad == 0, "R9 hold", 32'(stall_bad), 0);
        stall = 1'b0;

        // R10: bus error on second accepted write aborts RMII MAC sequence
        err_arm = 1'b1;
        err_at  = 1;
        launch(V_CFG[2]);
        wait_done();
        err_arm = 1'b0;
        chk(lg_n == 2, "R10 writes", 32'(lg_n), 2);
        chk(lg_d[1] == 32'h0A010940, "R10 last", lg_d[1], 32'h0A010940);
        chk(err == 1'b1 && done_n == 1, "R10 err", 32'(err), 1);
        repeat (3) @(negedge clk);
        chk(err == 1'b1, "R12 err held", 32'(err), 1);

        // R12: next start clears the error
        launch(V_CFG[8]);
        wait_done();
        chk(err == 1'b0, "R12 err cleared", 32'(err), 0);
        chk(lg_n == 1 && lg_d[0] == PADW, "R8 pad only", lg_d[0], PADW);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule